// File: doc/BRIEF.md
# Serial EEPROM Read Responder

This block is the target side of a two-wire serial EEPROM holding 256 bytes that software can only read. It does not watch the wires directly. A host hands it one sampled clock level and one sampled data level per update strobe, and it answers with the data level it holds. Between strobes the block is frozen, so the host sets the bit rate by how often it strobes.

Each transaction begins with a start condition. The responder then collects a command byte and an acknowledge slot, followed by an address byte. During the address byte it can also shift out the byte it fetched last. When the address byte is complete, it fetches the addressed byte from a fixed image and arms another acknowledge. If the command asks for a read, the next transaction's address phase returns that fetched byte, most significant bit first.

Top module: `serial_eeprom_responder`

## Requirements
- R1: After reset, `sda_out` is 1, no transaction is open, no acknowledge is pending and the read-data register is 0.
- R2: A start condition opens a transaction and clears the command register. A start is a strobe with clock high on both the previous and the current sample and data falling from 1 to 0. A start in the middle of a transaction restarts the bit count from the first command bit.
- R3: While no transaction is open and no acknowledge is pending, clock edges and data changes other than a start have no effect: no acknowledge is ever driven.
- R4: Bits are taken only on a clock rising edge (previous sample low, current high). A rising edge on which the data level differs from the previously stored level is discarded and does not advance the bit count.
- R5: After the eighth command bit, the next clock rising edge is an acknowledge slot. On that edge `sda_out` is 0 whatever the host drives, no bit is taken, and the pending acknowledge is cleared.
- R6: When command bit 0 is 1 (read), `sda_out` on each of the eight address-phase rising edges is the current MSB of the read-data register. That register shifts left by one on each of those edges.
- R7: When command bit 0 is 0 (write), `sda_out` on address-phase rising edges follows the host data level.
- R8: On the eighth address bit, the byte at the assembled address (first bit is the address MSB) is loaded into the read-data register. An acknowledge is armed and the transaction closes.
- R9: `sda_out` is always the most recently stored data level: the host level, or the level the responder forced on that strobe.
- R10: A stop condition closes the transaction and clears any pending acknowledge. A stop is clock high on both samples with data rising from 0 to 1.
- R11: The memory contents come from the image parameter, with byte i held in bits [8i+7:8i].
- R12: Without a strobe, no state and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Qualifies one sampled pair of line levels |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level driven by the host |
| sda_out | output | 1 | Data level held by the responder, as read back by the host |

## Verification
The bench keeps the default 256-byte depth and 8-bit width. It replaces the image with its own arithmetic pattern, byte i = (29*i + 7) mod 256, so fetched bytes cannot match the built-in default by chance. The addresses it uses (0x00, 0x01, 0x10, 0xC3, 0xFF) reach both ends of the array and mixed bit patterns. Chained read transactions are used because each one returns the byte fetched by the previous transaction. With them, the reset value of the data register and the load after a write command can both be seen at the pin.

// File: rtl/seprom_pkg.sv
package seprom_pkg;

    localparam int SEPROM_DEPTH  = 256;
    localparam int SEPROM_DATA_W = 8;

    // Classification of one sampled pair against the stored pair
    typedef enum logic [1:0] {
        LC_NONE  = 2'd0,
        LC_START = 2'd1,
        LC_STOP  = 2'd2,
        LC_RISE  = 2'd3
    } line_evt_e;

    function automatic logic [SEPROM_DEPTH*SEPROM_DATA_W-1:0] default_image();
        logic [SEPROM_DEPTH*SEPROM_DATA_W-1:0] img;
        img = '0;
        for (int i = 0; i < SEPROM_DEPTH; i++) begin
            img[i*SEPROM_DATA_W +: SEPROM_DATA_W] = SEPROM_DATA_W'(i) ^ SEPROM_DATA_W'(8'h5A);
        end
        return img;
    endfunction

endpackage

// File: rtl/seprom_linecond.sv
module seprom_linecond
    import seprom_pkg::*;
(
    input  logic      scl_prev,
    input  logic      sda_prev,
    input  logic      scl_now,
    input  logic      sda_now,
    output line_evt_e evt,
    output logic      level_held
);
    logic clk_high_both;

    always_comb begin
        clk_high_both = scl_prev & scl_now;
        level_held    = (sda_prev == sda_now);
        if (clk_high_both && !level_held) begin
            evt = sda_now ? LC_STOP : LC_START;
        end else if (!scl_prev && scl_now) begin
            evt = LC_RISE;
        end else begin
            evt = LC_NONE;
        end
    end

endmodule

// File: rtl/seprom_image_rom.sv
module seprom_image_rom #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8,
    parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            assign words[w] = IMAGE[w*DATA_W +: DATA_W];
        end
    endgenerate

    assign rdata = words[addr];

endmodule

// File: rtl/serial_eeprom_responder.sv
module serial_eeprom_responder
    import seprom_pkg::*;
#(
    parameter int DEPTH  = SEPROM_DEPTH,
    parameter int DATA_W = SEPROM_DATA_W,
    parameter logic [DEPTH*DATA_W-1:0] INIT_IMAGE = default_image()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out
);
    localparam int ADDR_W   = $clog2(DEPTH);
    localparam int CMD_END  = DATA_W + 1;
    localparam int ADDR_END = 2 * DATA_W + 1;
    localparam int TICK_W   = $clog2(ADDR_END + 1);
    localparam logic [TICK_W-1:0] T_FIRST = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_CMD   = TICK_W'(CMD_END);
    localparam logic [TICK_W-1:0] T_ADDR  = TICK_W'(ADDR_END);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              ack;
        logic [DATA_W-1:0] cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              scl;
        logic              sda;
    } resp_state_t;

    resp_state_t st_d, st_q;
    line_evt_e   evt;
    logic        held;
    logic [ADDR_W-1:0] addr_next;
    logic [DATA_W-1:0] fetched;
    logic [TICK_W-1:0] tick_inc;
    logic              sda_lvl;

    seprom_linecond u_cond (
        .scl_prev   (st_q.scl),
        .sda_prev   (st_q.sda),
        .scl_now    (scl_in),
        .sda_now    (sda_in),
        .evt        (evt),
        .level_held (held)
    );

    assign addr_next = {st_q.addr[ADDR_W-2:0], sda_in};
    assign tick_inc  = st_q.tick + T_FIRST;

    seprom_image_rom #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .IMAGE  (INIT_IMAGE)
    ) u_rom (
        .addr  (addr_next),
        .rdata (fetched)
    );

    always_comb begin
        st_d    = st_q;
        sda_lvl = sda_in;
        if (sample_stb) begin
            st_d.scl = scl_in;
            if (evt == LC_START) begin
                st_d.tick = T_FIRST;
                st_d.cmd  = '0;
            end else if (evt == LC_STOP) begin
                st_d.tick = '0;
                st_d.ack  = 1'b0;
            end else if (st_q.tick == '0 && !st_q.ack) begin
                // idle: wait for a start
            end else if (evt == LC_RISE) begin
                if (st_q.ack) begin
                    sda_lvl  = 1'b0;
                    st_d.ack = 1'b0;
                end else if (held) begin
                    if (st_q.tick < T_CMD) begin
                        st_d.cmd  = {st_q.cmd[DATA_W-2:0], sda_in};
                        st_d.tick = tick_inc;
                        if (tick_inc == T_CMD) begin
                            st_d.ack = 1'b1;
                        end
                    end else if (st_q.tick < T_ADDR) begin
                        if (st_q.cmd[0]) begin
                            sda_lvl = st_q.data[DATA_W-1];
                        end
                        st_d.addr = addr_next;
                        if (tick_inc == T_ADDR) begin
                            st_d.data = fetched;
                            st_d.ack  = 1'b1;
                            st_d.tick = '0;
                        end else begin
                            st_d.data = {st_q.data[DATA_W-2:0], 1'b0};
                            st_d.tick = tick_inc;
                        end
                    end else begin
                        sda_lvl = 1'b0;
                    end
                end
            end
            st_d.sda = sda_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.scl  <= 1'b1;
            st_q.sda  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_out = st_q.sda;

    // R5
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && st_q.ack && evt == LC_RISE) |=> (!sda_out && !st_q.ack));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && evt == LC_START) |=> (st_q.tick == T_FIRST && st_q.cmd == '0));

    // R10
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && evt == LC_STOP) |=> (st_q.tick == '0 && !st_q.ack));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && st_q.tick == '0 && !st_q.ack && evt != LC_START)
        |=> (st_q.tick == '0 && !st_q.ack));

    // R4
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && evt == LC_RISE && !held && !st_q.ack && st_q.tick != '0)
        |=> $stable(st_q.tick));

    // R12
    no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(st_q));

    // R8
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick < T_ADDR);

endmodule

// File: tb/serial_eeprom_responder_test.sv
`timescale 1ns/1ps
module serial_eeprom_responder_test;

    function automatic logic [2047:0] tb_image();
        logic [2047:0] img;
        for (int i = 0; i < 256; i++) begin
            img[i*8 +: 8] = 8'((29 * i + 7) % 256);
        end
        return img;
    endfunction

    localparam logic [2047:0] TB_IMG = tb_image();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic sda_out;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    serial_eeprom_responder #(
        .DEPTH      (256),
        .DATA_W     (8),
        .INIT_IMAGE (TB_IMG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .sda_out    (sda_out)
    );

    function automatic logic [7:0] mem_at(input logic [7:0] a);
        return TB_IMG[a*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic send_bit(input logic b, output logic seen);
        step(1'b0, b);
        step(1'b1, b);
        seen = sda_out;
        step(1'b0, b);
    endtask

    task automatic do_start();
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 idle level", sda_out, 1'b1);
    endtask

    task automatic t_ignore();
        logic s;
        logic any_low = 1'b0;
        for (int i = 0; i < 10; i++) begin
            send_bit(1'b1, s);
            if (!s) any_low = 1'b1;
        end
        chk("R3 no ack without start", any_low, 1'b0);
    endtask

    task automatic t_ack_cmd();
        logic s;
        logic [7:0] c = 8'hA4;
        do_start();
        for (int i = 7; i >= 0; i--) begin
            send_bit(c[i], s);
            chk("R9 echo during command", s, c[i]);
        end
        send_bit(1'b1, s);
        chk("R5 ack forced low", s, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 ack slot", sda_out, 1'b0);
        repeat (3) @(negedge clk);
        chk("R12 hold without strobe", sda_out, 1'b0);
        do_stop();
        chk("R9 stored host level after stop", sda_out, 1'b1);
    endtask

    task automatic t_glitch();
        logic s;
        do_start();
        for (int i = 0; i < 7; i++) send_bit(1'b0, s);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        send_bit(1'b1, s);
        chk("R4 glitched edge not counted", s, 1'b1);
        send_bit(1'b1, s);
        chk("R4 ack after eight clean bits", s, 1'b0);
        do_stop();
    endtask

    task automatic t_stop();
        logic s;
        logic any_low = 1'b0;
        do_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1, s);
        do_stop();
        for (int i = 0; i < 5; i++) begin
            send_bit(1'b1, s);
            if (!s) any_low = 1'b1;
        end
        chk("R10 stop closes transaction", any_low, 1'b0);
    endtask

    task automatic t_restart();
        logic s;
        logic any_low = 1'b0;
        do_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1, s);
        do_start();
        for (int i = 0; i < 8; i++) begin
            send_bit(1'b1, s);
            if (!s) any_low = 1'b1;
        end
        chk("R2 restart resets bit count", any_low, 1'b0);
        send_bit(1'b1, s);
        chk("R2 ack after eight bits from restart", s, 1'b0);
        do_stop();
    endtask

    task automatic t_xfer(input logic [7:0] cmd, input logic [7:0] a,
                          input logic [7:0] prev);
        logic s;
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(cmd[i], s);
        send_bit(1'b1, s);
        chk("R5 command ack", s, 1'b0);
        for (int i = 7; i >= 0; i--) begin
            send_bit(a[i], s);
            if (cmd[0]) chk("R6 read bit MSB first", s, prev[i]);
            else        chk("R7 write command echoes host", s, a[i]);
        end
        send_bit(1'b1, s);
        chk("R8 address ack", s, 1'b0);
        do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore();
        t_ack_cmd();
        t_glitch();
        t_stop();
        t_restart();
        t_xfer(8'hA1, 8'hC3, 8'h00);        // R1 data register reset value
        t_xfer(8'hA1, 8'h01, mem_at(8'hC3)); // R8 R11
        t_xfer(8'hA0, 8'h10, 8'h00);         // R7
        t_xfer(8'hA1, 8'hFF, mem_at(8'h10)); // R8 load after write command
        t_xfer(8'hA1, 8'h00, mem_at(8'hFF)); // R11 top byte
        t_xfer(8'hA1, 8'h00, mem_at(8'h00)); // R11 bottom byte
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule